// File: doc/BRIEF.md
# Two-Bank NOR Command Sequencer with Status Polling

This block is a synthesizable behavioural model of the command front end of a two-bank NOR-style flash. A bus master issues single-cycle write strobes carrying an address and a data byte. The block decodes them into program, sector-erase, bypass-mode, suspend and resume commands. Programming can only clear bits, and an erase returns every word of a sector to all ones. Both operations take a fixed number of clock cycles, set by parameters, so a test environment can observe the busy period.

While an operation runs, a read of any word in the affected bank returns a status byte instead of array contents. Bit 7 of that byte is the inverse of the target data, and bit 6 alternates from one status read to the next. Reads of the other bank return stored data and are not delayed. A running erase can be suspended so that other sectors can be read or programmed, and then resumed. A `ready` output is low while an operation is running.

Top module: `flash_cmd_seq`

## Requirements
- R1: After `rstN` is released, `ready` is 1 and every one of the 64 words reads as 8'hFF.
- R2: The write sequence (0x15,AA), (0x2A,55), (0x15,A0), (target,data) starts a program of the target word.
- R3: A program stores the old word AND the written data, so bits can only go from 1 to 0.
- R4: The sequence (0x15,AA), (0x2A,55), (0x15,20) enters bypass mode. In bypass mode, A0 written to any address followed by (target,data) programs the word. Writing 90 and then 00 leaves bypass mode, after which a lone A0 no longer starts a program.
- R5: The sequence (0x15,AA), (0x2A,55), (0x15,80), (0x15,AA), (0x2A,55), (sector address,30) erases the sector given by address bits [5:3]. All eight words of that sector become 8'hFF, and the other sectors are left unchanged.
- R6: The bank is selected by address bit 5. During an operation, a read from the busy bank returns {bit7, toggle, 6'b0}. Bit 7 is the inverse of bit 7 of the program data, or 0 for an erase. The toggle bit starts at 0 after reset and flips on every status read. Read data appears on the cycle after `rdEn`.
- R7: During an operation, reads from the other bank return stored array data.
- R8: `ready` falls on the cycle after the final write of a command. It stays low for PROG_CYCLES cycles for a program and ERASE_CYCLES cycles for an erase, then rises, and the block accepts a new command.
- R9: Writing B0 during an erase halts it and sets `ready` to 1. While the erase is halted:
  - reads of other sectors return array data;
  - reads of the halted sector return erase status;
  - programs to other sectors run normally;
  - programs to the halted sector are ignored.
  Writing 30 resumes the erase for its remaining cycles.
- R10: A write whose address or data does not fit the current step returns the decoder to its idle step without starting anything. Writes made while a program runs are ignored.
- R11: Pulling `rstN` low aborts any operation at once, sets `ready` to 1, and returns the array to all ones. The decoder then accepts commands normally.
- R12: While `lowSupply` is 1, every write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| lowSupply | input | 1 | Supply-low indication; blocks writes |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W | Word address for reads and writes |
| wrData | input | DATA_W | Command or program data |
| rdData | output | DATA_W | Registered read data or status byte |
| ready | output | 1 | High when no program or erase is running |

## Verification
A read result is registered, so it is due one cycle after `rdEn`. `ready` drops one cycle after the final write of a command. From that cycle it stays low for exactly PROG_CYCLES or ERASE_CYCLES cycles, minus any cycles already spent in the running part of a suspended erase. The bench drives every strobe for exactly one cycle and samples on the falling edge that follows. It counts falling edges from the end of the last write until `ready` rises and compares that count with the duration worked out from the parameters. The expected status bytes come from a toggle value that the bench tracks itself, and the expected array contents come from a bench-side copy of the array updated with AND for programs and all ones for erases.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  // Decoder position within a multi-cycle command.
  typedef enum logic [3:0] {
    SEQ_IDLE,
    SEQ_UNL1,
    SEQ_UNL2,
    SEQ_PGM,
    SEQ_ERS1,
    SEQ_ERS2,
    SEQ_ERS3,
    SEQ_EXIT
  } seqStep_t;

  // Strobes from control to the array datapath.
  typedef struct packed {
    logic progBusy;
    logic eraseRun;
    logic eraseHeld;
    logic commitProg;
    logic commitErase;
  } ctrlStrobe_t;

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 8,
  parameter int SECT_OFS_W   = 3,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 20,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR_A = 6'h15,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR_B = 6'h2A,
  parameter logic [DATA_W-1:0] CODE_UNLOCK_A = 8'hAA,
  parameter logic [DATA_W-1:0] CODE_UNLOCK_B = 8'h55,
  parameter logic [DATA_W-1:0] CMD_PROGRAM   = 8'hA0,
  parameter logic [DATA_W-1:0] CMD_ERASE_SET = 8'h80,
  parameter logic [DATA_W-1:0] CMD_ERASE_GO  = 8'h30,
  parameter logic [DATA_W-1:0] CMD_BYP_ENTER = 8'h20,
  parameter logic [DATA_W-1:0] CMD_BYP_EXIT  = 8'h90,
  parameter logic [DATA_W-1:0] CMD_BYP_DONE  = 8'h00,
  parameter logic [DATA_W-1:0] CMD_SUSPEND   = 8'hB0,
  parameter logic [DATA_W-1:0] CMD_RESUME    = 8'h30
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       lowSupply,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wrData,
  output ctrlStrobe_t                strb,
  output logic [ADDR_W-1:0]          opAddr,
  output logic [DATA_W-1:0]          opData,
  output logic [ADDR_W-SECT_OFS_W-1:0] eraseSector
);

  localparam int SECT_W = ADDR_W - SECT_OFS_W;
  localparam int PCNT_W = $clog2(PROG_CYCLES + 1);
  localparam int ECNT_W = $clog2(ERASE_CYCLES + 1);

  seqStep_t            step, stepNext;
  logic                bypass, bypassNext;
  logic                progBusy, eraseRun, eraseHeld;
  logic [PCNT_W-1:0]   progCnt;
  logic [ECNT_W-1:0]   eraseCnt;
  logic                wrOk, cmdOpen, isA, isB;
  logic                startProg, startErase, doResume;
  logic                commitProg, commitErase;
  logic [SECT_W-1:0]   targetSect;

  assign wrOk        = wrEn && !lowSupply;
  assign cmdOpen     = wrOk && !progBusy && !eraseRun;
  assign isA         = (addr == UNLOCK_ADDR_A);
  assign isB         = (addr == UNLOCK_ADDR_B);
  assign targetSect  = addr[ADDR_W-1:SECT_OFS_W];
  assign commitProg  = progBusy && (progCnt == '0);
  assign commitErase = eraseRun && (eraseCnt == '0);

  // Command decoder: a mismatched cycle falls back to idle.
  always_comb begin
    stepNext   = step;
    bypassNext = bypass;
    startProg  = 1'b0;
    startErase = 1'b0;
    doResume   = 1'b0;
    if (cmdOpen) begin
      stepNext = SEQ_IDLE;
      case (step)
        SEQ_IDLE: begin
          if (eraseHeld && wrData == CMD_RESUME) doResume = 1'b1;
          else if (bypass) begin
            if (wrData == CMD_PROGRAM)       stepNext = SEQ_PGM;
            else if (wrData == CMD_BYP_EXIT) stepNext = SEQ_EXIT;
          end else if (isA && wrData == CODE_UNLOCK_A) stepNext = SEQ_UNL1;
        end
        SEQ_UNL1: if (isB && wrData == CODE_UNLOCK_B) stepNext = SEQ_UNL2;
        SEQ_UNL2: begin
          if (isA) begin
            if (wrData == CMD_PROGRAM)                     stepNext = SEQ_PGM;
            else if (wrData == CMD_ERASE_SET && !eraseHeld) stepNext = SEQ_ERS1;
            else if (wrData == CMD_BYP_ENTER)              bypassNext = 1'b1;
          end
        end
        SEQ_PGM:  startProg = !(eraseHeld && targetSect == eraseSector);
        SEQ_ERS1: if (isA && wrData == CODE_UNLOCK_A) stepNext = SEQ_ERS2;
        SEQ_ERS2: if (isB && wrData == CODE_UNLOCK_B) stepNext = SEQ_ERS3;
        SEQ_ERS3: startErase = (wrData == CMD_ERASE_GO);
        SEQ_EXIT: if (wrData == CMD_BYP_DONE) bypassNext = 1'b0;
        default:  stepNext = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step        <= SEQ_IDLE;
      bypass      <= 1'b0;
      progBusy    <= 1'b0;
      progCnt     <= '0;
      eraseRun    <= 1'b0;
      eraseHeld   <= 1'b0;
      eraseCnt    <= '0;
      opAddr      <= '0;
      opData      <= '0;
      eraseSector <= '0;
    end else begin
      step   <= stepNext;
      bypass <= bypassNext;

      // Program timer
      if (startProg) begin
        progBusy <= 1'b1;
        progCnt  <= PCNT_W'(PROG_CYCLES - 1);
        opAddr   <= addr;
        opData   <= wrData;
      end else if (commitProg) begin
        progBusy <= 1'b0;
      end else if (progBusy) begin
        progCnt <= progCnt - 1'b1;
      end

      // Erase timer; completion wins over a same-cycle suspend
      if (startErase) begin
        eraseRun    <= 1'b1;
        eraseCnt    <= ECNT_W'(ERASE_CYCLES - 1);
        eraseSector <= targetSect;
      end else if (commitErase) begin
        eraseRun <= 1'b0;
      end else if (eraseRun) begin
        eraseCnt <= eraseCnt - 1'b1;
        if (wrOk && wrData == CMD_SUSPEND) begin
          eraseRun  <= 1'b0;
          eraseHeld <= 1'b1;
        end
      end else if (doResume) begin
        eraseRun  <= 1'b1;
        eraseHeld <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.progBusy    = progBusy;
    strb.eraseRun    = eraseRun;
    strb.eraseHeld   = eraseHeld;
    strb.commitProg  = commitProg;
    strb.commitErase = commitErase;
  end

endmodule

// File: rtl/flash_seq_array.sv
module flash_seq_array
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int SECT_OFS_W = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         rdEn,
  input  logic [ADDR_W-1:0]            addr,
  input  ctrlStrobe_t                  strb,
  input  logic [ADDR_W-1:0]            opAddr,
  input  logic [DATA_W-1:0]            opData,
  input  logic [ADDR_W-SECT_OFS_W-1:0] eraseSector,
  output logic [DATA_W-1:0]            rdData
);

  localparam int WORDS      = 1 << ADDR_W;
  localparam int SECT_W     = ADDR_W - SECT_OFS_W;
  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;

  logic [DATA_W-1:0] mem [WORDS];
  logic              toggleQ;
  logic              progHit, eraseHit;
  logic [SECT_W-1:0] rdSect;
  logic [DATA_W-1:0] statusWord;

  assign rdSect   = addr[ADDR_W-1:SECT_OFS_W];
  assign progHit  = strb.progBusy && (addr[ADDR_W-1] == opAddr[ADDR_W-1]);
  assign eraseHit = (strb.eraseRun && (addr[ADDR_W-1] == eraseSector[SECT_W-1]))
                 || (strb.eraseHeld && (rdSect == eraseSector));

  always_comb begin
    statusWord             = '0;
    statusWord[POLL_BIT]   = progHit ? ~opData[POLL_BIT] : 1'b0;
    statusWord[TOGGLE_BIT] = toggleQ;
  end

  // Array storage: erase fills a sector, program ANDs one word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '1;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (strb.commitErase && (SECT_W'(w >> SECT_OFS_W) == eraseSector))
          mem[w] <= '1;
        else if (strb.commitProg && (ADDR_W'(w) == opAddr))
          mem[w] <= mem[w] & opData;
      end
    end
  end

  // Registered read port with status substitution
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      toggleQ <= 1'b0;
    end else if (rdEn) begin
      if (progHit || eraseHit) begin
        rdData  <= statusWord;
        toggleQ <= ~toggleQ;
      end else begin
        rdData <= mem[addr];
      end
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 8,
  parameter int SECT_OFS_W   = 3,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lowSupply,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              ready
);

  localparam int SECT_W = ADDR_W - SECT_OFS_W;

  ctrlStrobe_t       strb;
  logic [ADDR_W-1:0] opAddr;
  logic [DATA_W-1:0] opData;
  logic [SECT_W-1:0] eraseSector;

  flash_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_OFS_W(SECT_OFS_W),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .lowSupply(lowSupply), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .strb(strb),
    .opAddr(opAddr), .opData(opData), .eraseSector(eraseSector)
  );

  flash_seq_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_OFS_W(SECT_OFS_W)
  ) uArray (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .addr(addr), .strb(strb),
    .opAddr(opAddr), .opData(opData), .eraseSector(eraseSector),
    .rdData(rdData)
  );

  assign ready = !(strb.progBusy || strb.eraseRun);

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_seq_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        lowSupply,
  input logic        ready,
  input ctrlStrobe_t strb
);

  assert_supply_blocks_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ready && lowSupply) |=> ready);

  assert_busy_needs_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !(wrEn && !lowSupply)) |=> ready);

  assert_ready_after_commit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitProg || strb.commitErase) |=> ready);

  assert_single_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.commitProg, strb.commitErase}));

  assert_held_not_running_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.eraseHeld |-> !strb.eraseRun);

  assert_prog_excludes_erase_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.progBusy |-> !strb.eraseRun);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .lowSupply(lowSupply),
  .ready(ready), .strb(strb)
);

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;

  localparam int AW = 6, DW = 8, OFS = 3, PC = 6, EC = 20;
  localparam int WORDS = 1 << AW;
  localparam logic [AW-1:0] UA = 6'h15, UB = 6'h2A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, lowSupply, wrEn, rdEn, ready;
  logic [AW-1:0] addr;
  logic [DW-1:0] wrData, rdData, v;
  logic [DW-1:0] shadow [WORDS];
  logic tgl;
  int nChecks = 0, nFail = 0, n;

  flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .SECT_OFS_W(OFS),
                  .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (
    .clk(clk), .rstN(rstN), .lowSupply(lowSupply), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .ready(ready));

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] q);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    q = rdData;
  endtask

  task automatic progCmd(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'hA0); wr(a, d);
  endtask

  task automatic eraseCmd(input int s);
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'h80);
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(AW'(s << OFS), 8'h30);
  endtask

  task automatic waitReady(output int cnt);
    cnt = 0;
    while (!ready && cnt < 1000) begin @(negedge clk); cnt++; end
  endtask

  task automatic checkWord(input string req, input int a);
    logic [DW-1:0] q;
    rd(AW'(a), q);
    check(req, q, shadow[a]);
  endtask

  task automatic checkStatus(input string req, input int a, input logic b7);
    logic [DW-1:0] q;
    rd(AW'(a), q);
    check(req, q, {b7, tgl, 6'b0});
    tgl = ~tgl;
  endtask

  task automatic eraseShadow(input int s);
    for (int w = 0; w < WORDS; w++) if ((w >> OFS) == s) shadow[w] = 8'hFF;
  endtask

  function automatic logic [DW-1:0] pat(input int w);
    return DW'((w * 37 + 91) & 255);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; lowSupply = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    addr = '0; wrData = '0; tgl = 1'b0;
    for (int w = 0; w < WORDS; w++) shadow[w] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 ready", ready, 1);
    for (int w = 0; w < WORDS; w++) checkWord("R1 erased array", w);

    // R2/R6/R7/R8: normal program with polling
    progCmd(6'd3, 8'h5A);
    check("R8 ready low", ready, 0);
    checkStatus("R6 poll bit7", 9, 1'b1);
    checkStatus("R6 toggle", 10, 1'b1);
    checkWord("R7 other bank", 40);
    waitReady(n);
    check("R8 program duration", n, PC - 3);
    shadow[3] = shadow[3] & 8'h5A;
    checkWord("R2 programmed", 3);

    // R3: program only clears bits
    progCmd(6'd3, 8'hF0);
    waitReady(n);
    check("R8 full program duration", n, PC);
    shadow[3] = shadow[3] & 8'hF0;
    checkWord("R3 and", 3);

    // R10: out-of-order sequence
    wr(UA, 8'hAA); wr(UA, 8'h55); wr(UA, 8'hA0); wr(6'd5, 8'h00);
    check("R10 no start", ready, 1);
    checkWord("R10 unchanged", 5);

    // R10: writes during a program are ignored
    progCmd(6'd7, 8'h0F);
    progCmd(6'd8, 8'h00);
    waitReady(n);
    check("R10 ready after", ready, 1);
    shadow[7] = shadow[7] & 8'h0F;
    checkWord("R10 target", 7);
    checkWord("R10 busy write ignored", 8);

    // R4: bypass sweep over every word
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'h20);
    for (int w = 0; w < WORDS; w++) begin
      wr(6'd0, 8'hA0);
      wr(AW'(w), pat(w));
      waitReady(n);
      check("R4 bypass duration", n, PC);
      shadow[w] = shadow[w] & pat(w);
    end
    for (int w = 0; w < WORDS; w++) checkWord("R4 bypass data", w);
    wr(6'd0, 8'h90); wr(6'd0, 8'h00);
    wr(6'd0, 8'hA0); wr(6'd2, 8'h00);
    check("R4 exit no start", ready, 1);
    checkWord("R4 exit unchanged", 2);

    // R5/R6/R7: erase each sector
    for (int s = 0; s < 8; s++) begin
      eraseCmd(s);
      check("R8 erase ready low", ready, 0);
      checkWord("R7 erase other bank", (s < 4) ? 40 : 3);
      checkStatus("R6 erase status", (s < 4) ? ((s + 1) % 4) * 8 : 32 + ((s - 3) % 4) * 8, 1'b0);
      waitReady(n);
      check("R8 erase duration", n, EC - 2);
      eraseShadow(s);
      for (int w = 0; w < WORDS; w++) checkWord("R5 erase result", w);
    end

    // R9: suspend and resume
    progCmd(6'd1, 8'h3C);
    waitReady(n);
    shadow[1] = 8'h3C;
    eraseCmd(1);
    repeat (4) @(negedge clk);
    wr(6'd0, 8'hB0);
    check("R9 suspended ready", ready, 1);
    checkStatus("R9 held sector status", 12, 1'b0);
    checkWord("R9 same bank read", 1);
    progCmd(6'd9, 8'h00);
    check("R9 held sector program ignored", ready, 1);
    progCmd(6'd20, 8'hA5);
    check("R9 program in suspend", ready, 0);
    waitReady(n);
    check("R9 program duration", n, PC);
    shadow[20] = 8'hA5;
    checkWord("R9 program result", 20);
    wr(6'd0, 8'h30);
    check("R9 resumed", ready, 0);
    waitReady(n);
    check("R9 remaining cycles", n, EC - 5);
    eraseShadow(1);
    for (int w = 0; w < 24; w++) checkWord("R9 after resume", w);

    // R12: low supply blocks writes
    lowSupply = 1'b1;
    progCmd(6'd30, 8'h00);
    check("R12 no program", ready, 1);
    eraseCmd(3);
    check("R12 no erase", ready, 1);
    lowSupply = 1'b0;
    checkWord("R12 unchanged", 30);
    checkWord("R12 sector kept", 20);

    // R11: hardware reset aborts
    progCmd(6'd30, 8'h00);
    check("R11 busy before reset", ready, 0);
    rstN = 1'b0;
    @(negedge clk);
    check("R11 ready in reset", ready, 1);
    rstN = 1'b1;
    @(negedge clk);
    for (int w = 0; w < WORDS; w++) shadow[w] = 8'hFF;
    tgl = 1'b0;
    checkWord("R11 aborted word", 30);
    checkWord("R11 array reset", 1);
    progCmd(6'd30, 8'h81);
    waitReady(n);
    check("R11 accepts command", n, PC);
    shadow[30] = 8'h81;
    checkWord("R11 program after reset", 30);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule